// File: doc/BRIEF.md
# Linked Display Descriptor Fetch Controller

This block drives the parameter side of one graphics display plane. Software builds plane descriptors in memory. Each descriptor is a 16-word record that holds a control word, a source pixel address, a line pitch, a source size, a screen viewport, plane property flags and a link to the following descriptor. On every vertical sync pulse the block takes its next-node pointer and reads the whole record through a single-outstanding read port. It then publishes the new plane parameters to the pixel path in one step. It also reloads its pointer from the record's link word, so a chain of records is walked without software help. A typical chain has a top-field record and a bottom-field record that link to each other, and the bottom record's pixel address is one pitch above the top one.

Software reaches the next-node pointer through a one-register write/read port. A rewrite only changes what is fetched at the next vsync. If software rewrites the pointer while a fetch is running, the written value is kept, and the link word of the record in flight does not overwrite it. A zero pointer idles the chain. A pointer that is not 16-byte aligned is refused: nothing is fetched, the parameters stay as they were, and a sticky error flag is raised. The current field output holds the field input as it was sampled at the last vsync.

Top module: `plane_desc_walker`

## Requirements
- R1: After reset all plane outputs, the pointer read-back, the error flag and the current field are zero, and no read request is issued.
- R2: A write on the register port sets the next-node pointer, and the read-back shows the written value from the following cycle on.
- R3: A vsync while the pointer is zero issues no read request and leaves all plane outputs unchanged.
- R4: A vsync with a nonzero aligned pointer P issues exactly 16 read requests at byte addresses P, P+4, ..., P+60, in this order. Each request is a one-cycle pulse, and the next request is only issued after the data of the previous one has returned.
- R5: Plane outputs keep their old values while a fetch runs. In the cycle after the 16th data word they all change together. The control output takes word offset 0x00, the source address 0x14, the pitch 0x18, and the first line/first pixel the upper/lower halves of 0x0C. The last line/last pixel take the upper/lower halves of 0x10.
- R6: When a fetch completes, the next-node pointer is loaded from word offset 0x24 of the fetched record.
- R7: A register write made during a fetch, including in its first or last cycle, takes priority over the link word at completion.
- R8: Source height is bits 31:16 and source width bits 15:0 of word offset 0x1C. Each is output as an 11-bit value, and a value above 0x7FF is output as 0x7FF.
- R9: The ignore output is 1 only when bits 1:0 of word offset 0x34 are both 1.
- R10: A vsync with a nonzero pointer whose bits 3:0 are not zero issues no request, keeps the plane outputs, and sets the error flag, which stays set until reset.
- R11: The current field output takes the value of the field input at every vsync (1 = bottom), whatever the pointer holds.
- R12: A vsync that arrives while a fetch runs neither restarts nor extends the fetch.
- R13: A top and a bottom record that link to each other are presented alternately on successive vsyncs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_i | input | 1 | One-cycle vertical sync pulse |
| field_i | input | 1 | Field of the coming frame, 1 = bottom |
| reg_wr_i | input | 1 | Write strobe for the next-node pointer |
| reg_wdata_i | input | AW | Pointer value to write |
| reg_rdata_o | output | AW | Pointer that the next vsync will fetch |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | AW | Byte address of the requested word |
| rd_vld_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data word |
| ctrl_o | output | 32 | Active control word |
| src_addr_o | output | 32 | Active source pixel address |
| pitch_o | output | 32 | Active source line pitch |
| src_w_o | output | 11 | Active source width, limited |
| src_h_o | output | 11 | Active source height, limited |
| vp_x0_o | output | 16 | First viewport pixel |
| vp_y0_o | output | 16 | First viewport line |
| vp_x1_o | output | 16 | Last viewport pixel |
| vp_y1_o | output | 16 | Last viewport line |
| ignore_o | output | 1 | Plane is to be skipped by the mixer |
| field_o | output | 1 | Field sampled at the last vsync |
| err_o | output | 1 | Sticky misaligned-pointer flag |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 16-byte record alignment. With these values a pointer such as 0x44 is a misaligned case, and three records fit in a 256-byte memory model. The model's response delay is a run-time setting. It is first one cycle and then three cycles, so the one-outstanding request spacing is seen under both short and long waits. Pointer writes are made in the middle of a fetch, and a second vsync is issued while a fetch is still running. Sizes are taken just over the 0x7FF limit and exactly on it.

// File: rtl/dsc_pkg.sv
// Shared constants and the plane-record type for the descriptor walker.
// Assumes 32-bit descriptor words; word indices follow the record layout.
package dsc_pkg;
    localparam int WORD_W    = 32;
    localparam int DSC_WORDS = 16;
    localparam int IDX_W     = $clog2(DSC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DSC_WORDS - 1);

    // Word indices inside a record (byte offset / 4)
    localparam logic [IDX_W-1:0] W_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] W_VPO  = IDX_W'(3);
    localparam logic [IDX_W-1:0] W_VPS  = IDX_W'(4);
    localparam logic [IDX_W-1:0] W_PIX  = IDX_W'(5);
    localparam logic [IDX_W-1:0] W_PTCH = IDX_W'(6);
    localparam logic [IDX_W-1:0] W_SIZE = IDX_W'(7);
    localparam logic [IDX_W-1:0] W_LINK = IDX_W'(9);
    localparam logic [IDX_W-1:0] W_PROP = IDX_W'(13);

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] vp_org;
        logic [WORD_W-1:0] vp_end;
        logic [WORD_W-1:0] pix;
        logic [WORD_W-1:0] pitch;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] prop;
    } plane_rec_t;
endpackage

// File: rtl/dsc_seq.sv
// Fetch sequencer: on an accepted vsync, walks the 16 words of the record at
// the next-node pointer with one read in flight. Assumes ALIGN_B >= 4 and a
// power of two; rd_vld_i outside a wait phase is ignored.
module dsc_seq
    import dsc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ALIGN_B = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic [AW-1:0]    nxt_i,
    output logic             start_o,
    output logic             err_set_o,
    output logic             rd_req_o,
    output logic [AW-1:0]    rd_addr_o,
    input  logic             rd_vld_i,
    output logic             cap_en_o,
    output logic [IDX_W-1:0] cap_idx_o,
    output logic             commit_o
);
    localparam int ALN_LSB = $clog2(ALIGN_B);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_st_t;

    seq_st_t          st_q;
    logic [AW-1:0]    base_q;
    logic [IDX_W-1:0] idx_q;
    logic             ptr_live, ptr_aligned;

    // Pointer qualification at vsync time
    always_comb begin
        ptr_live    = (nxt_i != '0);
        ptr_aligned = (nxt_i[ALN_LSB-1:0] == '0);
        start_o     = (st_q == S_IDLE) && vsync_i && ptr_live && ptr_aligned;
        err_set_o   = (st_q == S_IDLE) && vsync_i && ptr_live && !ptr_aligned;
    end

    // Request and capture strobes
    always_comb begin
        rd_req_o  = (st_q == S_REQ);
        rd_addr_o = base_q + (AW'(idx_q) << 2);
        cap_en_o  = (st_q == S_WAIT) && rd_vld_i;
        cap_idx_o = idx_q;
        commit_o  = cap_en_o && (idx_q == LAST_IDX);
    end

    // State, record base and word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            base_q <= '0;
            idx_q  <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start_o) begin
                    base_q <= nxt_i;
                    idx_q  <= '0;
                    st_q   <= S_REQ;
                end
                S_REQ:  st_q <= S_WAIT;
                S_WAIT: if (rd_vld_i) begin
                    if (idx_q == LAST_IDX) begin
                        st_q <= S_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= S_REQ;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R4
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R4
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o[1:0] == 2'b00));
endmodule

// File: rtl/dsc_capture.sv
// Record capture: collects the words the plane needs into a shadow record
// as they arrive, then copies the shadow to the active record in the cycle
// of the last word. Assumes the last word of a record is not one it uses.
module dsc_capture
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic [IDX_W-1:0]  cap_idx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              commit_i,
    output plane_rec_t        act_o
);
    plane_rec_t shd_q;
    plane_rec_t act_q;

    // Shadow fill, one field per captured word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else if (cap_en_i) begin
            case (cap_idx_i)
                W_CTRL:  shd_q.ctrl   <= word_i;
                W_VPO:   shd_q.vp_org <= word_i;
                W_VPS:   shd_q.vp_end <= word_i;
                W_PIX:   shd_q.pix    <= word_i;
                W_PTCH:  shd_q.pitch  <= word_i;
                W_SIZE:  shd_q.size   <= word_i;
                W_LINK:  shd_q.link   <= word_i;
                W_PROP:  shd_q.prop   <= word_i;
                default: ;
            endcase
        end
    end

    // Atomic publish of the whole record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (commit_i) begin
            act_q <= shd_q;
        end
    end

    assign act_o = act_q;

    // R5
    hold_between_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(act_q));
endmodule

// File: rtl/dsc_ptr.sv
// Next-node pointer: software writes land at once; a completed fetch loads
// the record's link unless software wrote since that fetch took its pointer.
module dsc_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          start_i,
    input  logic          commit_i,
    input  logic [AW-1:0] link_i,
    output logic [AW-1:0] nxt_o
);
    logic [AW-1:0] nxt_q;
    logic          sw_ovr_q;

    // Marks a software write made after the running fetch sampled the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_ovr_q <= 1'b0;
        else if (wr_i)    sw_ovr_q <= 1'b1;
        else if (start_i) sw_ovr_q <= 1'b0;
    end

    // Pointer update, software first, then chain link
    always_ff @(posedge clk) begin
        if (!rst_n)                     nxt_q <= '0;
        else if (wr_i)                  nxt_q <= wdata_i;
        else if (commit_i && !sw_ovr_q) nxt_q <= link_i;
    end

    assign nxt_o = nxt_q;

    // R2, R7
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (nxt_q == $past(wdata_i)));
endmodule

// File: rtl/plane_desc_walker.sv
// Top of the descriptor walker: ties pointer, sequencer and capture together,
// samples the field at vsync, keeps the sticky alignment error and derives
// the plane outputs from the active record. Assumes vsync_i is one cycle wide.
module plane_desc_walker
    import dsc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ALIGN_B = 16,
    parameter int SZW     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              field_i,
    input  logic              reg_wr_i,
    input  logic [AW-1:0]     reg_wdata_i,
    output logic [AW-1:0]     reg_rdata_o,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic              rd_vld_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] src_addr_o,
    output logic [WORD_W-1:0] pitch_o,
    output logic [SZW-1:0]    src_w_o,
    output logic [SZW-1:0]    src_h_o,
    output logic [15:0]       vp_x0_o,
    output logic [15:0]       vp_y0_o,
    output logic [15:0]       vp_x1_o,
    output logic [15:0]       vp_y1_o,
    output logic              ignore_o,
    output logic              field_o,
    output logic              err_o
);
    localparam logic [15:0] SZ_LIM = 16'((1 << SZW) - 1);

    logic [AW-1:0]    nxt;
    logic             start, err_set, cap_en, commit;
    logic [IDX_W-1:0] cap_idx;
    plane_rec_t       act;
    logic             field_q, err_q;

    dsc_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .start_i  (start),
        .commit_i (commit),
        .link_i   (AW'(act_link_next())),
        .nxt_o    (nxt)
    );

    dsc_seq #(.AW(AW), .ALIGN_B(ALIGN_B)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_i   (vsync_i),
        .nxt_i     (nxt),
        .start_o   (start),
        .err_set_o (err_set),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_vld_i  (rd_vld_i),
        .cap_en_o  (cap_en),
        .cap_idx_o (cap_idx),
        .commit_o  (commit)
    );

    dsc_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en_i (cap_en),
        .cap_idx_i(cap_idx),
        .word_i   (rd_data_i),
        .commit_i (commit),
        .act_o    (act)
    );

    // Link word of the record being committed, taken from the shadow copy
    function automatic logic [WORD_W-1:0] act_link_next();
        return u_cap.shd_q.link;
    endfunction

    // Field sample at each vsync
    always_ff @(posedge clk) begin
        if (!rst_n)       field_q <= 1'b0;
        else if (vsync_i) field_q <= field_i;
    end

    // Sticky misaligned-pointer flag
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    // Size limiting of each half of the size word
    function automatic logic [SZW-1:0] lim(input logic [15:0] v);
        return (v > SZ_LIM) ? SZ_LIM[SZW-1:0] : v[SZW-1:0];
    endfunction

    // Plane output decode from the active record
    always_comb begin
        ctrl_o     = act.ctrl;
        src_addr_o = act.pix;
        pitch_o    = act.pitch;
        src_h_o    = lim(act.size[31:16]);
        src_w_o    = lim(act.size[15:0]);
        vp_y0_o    = act.vp_org[31:16];
        vp_x0_o    = act.vp_org[15:0];
        vp_y1_o    = act.vp_end[31:16];
        vp_x1_o    = act.vp_end[15:0];
        ignore_o   = (act.prop[1:0] == 2'b11);
    end

    assign reg_rdata_o = nxt;
    assign field_o     = field_q;
    assign err_o       = err_q;

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R11
    field_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> (field_q == $past(field_i)));

    // R3
    zero_ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_i && nxt == '0 && !rd_req_o && !cap_en) |=> !rd_req_o);
endmodule

// File: tb/test_plane_desc_walker.sv
module test_plane_desc_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0, field = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        rd_req, rd_vld;
    logic [31:0] rd_addr, rd_data;
    logic [31:0] ctrl, src_addr, pitch;
    logic [10:0] src_w, src_h;
    logic [15:0] vx0, vy0, vx1, vy1;
    logic        ignore, fld_o, err;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int lat = 1;
    int req_cnt = 0;
    logic [31:0] req_log [0:63];
    logic [31:0] mem [0:63];
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] a_l = '0;

    always #10 clk = ~clk;

    plane_desc_walker i_plane_desc_walker (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .field_i(field),
        .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_vld_i(rd_vld), .rd_data_i(rd_data),
        .ctrl_o(ctrl), .src_addr_o(src_addr), .pitch_o(pitch),
        .src_w_o(src_w), .src_h_o(src_h),
        .vp_x0_o(vx0), .vp_y0_o(vy0), .vp_x1_o(vx1), .vp_y1_o(vy1),
        .ignore_o(ignore), .field_o(fld_o), .err_o(err)
    );

    // Memory model: one request in flight, response after lat cycles
    always @(posedge clk) begin
        rd_vld <= 1'b0;
        if (rd_req) begin
            if (req_cnt < 64) req_log[req_cnt] = rd_addr;
            req_cnt = req_cnt + 1;
            pend <= 1'b1;
            cnt  <= lat - 1;
            a_l  <= rd_addr;
        end else if (pend) begin
            if (cnt == 0) begin
                rd_vld  <= 1'b1;
                rd_data <= mem[a_l[7:2]];
                pend    <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int base, input logic [31:0] c, vpo, vps, pix,
                            ptch, sz, lnk, prp);
        int w;
        w = base >> 2;
        for (int k = 0; k < 16; k++) mem[w + k] = 32'hA5A5_0000 + k;
        mem[w + 0] = c;   mem[w + 3] = vpo;  mem[w + 4] = vps;
        mem[w + 5] = pix; mem[w + 6] = ptch; mem[w + 7] = sz;
        mem[w + 9] = lnk; mem[w + 13] = prp;
    endtask

    task automatic pulse_vsync(input logic f);
        @(negedge clk); field = f; vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
    endtask

    task automatic write_ptr(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ctrl", ctrl, 0);       chk("R1 src", src_addr, 0);
        chk("R1 rdata", reg_rdata, 0); chk("R1 err", {31'b0, err}, 0);
        chk("R1 field", {31'b0, fld_o}, 0);
        chk("R1 req", {31'b0, rd_req}, 0);
    endtask

    task automatic t_zero_ptr();
        int c0;
        c0 = req_cnt;
        pulse_vsync(1'b1);
        settle();
        chk("R3 no request", req_cnt - c0, 0);
        chk("R3 ctrl kept", ctrl, 0);
        chk("R11 field bottom", {31'b0, fld_o}, 1);
    endtask

    task automatic t_first_fetch();
        int c0;
        write_ptr(32'h40);
        chk("R2 readback", reg_rdata, 32'h40);
        c0 = req_cnt;
        pulse_vsync(1'b0);
        repeat (10) @(negedge clk);
        chk("R5 old value mid-fetch", ctrl, 0);
        settle();
        chk("R4 request count", req_cnt - c0, 16);
        for (int i = 0; i < 16; i++)
            chk("R4 request order", req_log[c0 + i], 32'h40 + 4 * i);
        chk("R5 ctrl", ctrl, 32'h8000_0005);
        chk("R5 src", src_addr, 32'h1000_0000);
        chk("R5 pitch", pitch, 32'h0000_0A00);
        chk("R5 vp first", {vy0, vx0}, 32'h0010_0020);
        chk("R5 vp last", {vy1, vx1}, 32'h01DF_02CF);
        chk("R8 width", {21'b0, src_w}, 32'h280);
        chk("R8 height", {21'b0, src_h}, 32'h1E0);
        chk("R9 one bit only", {31'b0, ignore}, 0);
        chk("R6 link loaded", reg_rdata, 32'h80);
        chk("R11 field top", {31'b0, fld_o}, 0);
    endtask

    task automatic t_chain();
        pulse_vsync(1'b1);
        settle();
        chk("R13 bottom src", src_addr, 32'h1000_0A00);
        chk("R9 ignore set", {31'b0, ignore}, 1);
        chk("R8 width limited", {21'b0, src_w}, 32'h7FF);
        chk("R8 height limited", {21'b0, src_h}, 32'h7FF);
        chk("R13 link back", reg_rdata, 32'h40);
        pulse_vsync(1'b0);
        settle();
        chk("R13 top again", src_addr, 32'h1000_0000);
        chk("R13 ctrl top", ctrl, 32'h8000_0005);
    endtask

    task automatic t_sw_override();
        lat = 3;
        pulse_vsync(1'b1);
        repeat (6) @(negedge clk);
        write_ptr(32'hC0);
        settle();
        chk("R7 write kept", reg_rdata, 32'hC0);
        chk("R7 fetch used old pointer", ctrl, 32'h8000_0002);
    endtask

    task automatic t_vsync_busy();
        int c0;
        c0 = req_cnt;
        pulse_vsync(1'b0);
        repeat (6) @(negedge clk);
        pulse_vsync(1'b1);
        settle();
        chk("R12 single fetch", req_cnt - c0, 16);
        chk("R12 record C", ctrl, 32'h8000_0003);
        chk("R8 exact limit h", {21'b0, src_h}, 32'h7FF);
        chk("R8 exact limit w", {21'b0, src_w}, 32'h001);
    endtask

    task automatic t_misaligned();
        int c0;
        write_ptr(32'h44);
        c0 = req_cnt;
        pulse_vsync(1'b0);
        settle();
        chk("R10 no request", req_cnt - c0, 0);
        chk("R10 err set", {31'b0, err}, 1);
        chk("R10 params kept", ctrl, 32'h8000_0003);
        write_ptr(32'h40);
        pulse_vsync(1'b0);
        settle();
        chk("R10 err sticky", {31'b0, err}, 1);
        chk("R10 fetch resumes", ctrl, 32'h8000_0005);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        put_desc(32'h40, 32'h8000_0005, 32'h0010_0020, 32'h01DF_02CF, 32'h1000_0000,
                 32'h0000_0A00, 32'h01E0_0280, 32'h80, 32'h2);
        put_desc(32'h80, 32'h8000_0002, 32'h0010_0020, 32'h01DF_02CF, 32'h1000_0A00,
                 32'h0000_0A00, 32'h0900_0800, 32'h40, 32'h3);
        put_desc(32'hC0, 32'h8000_0003, 32'h0, 32'h0, 32'h2000_0000,
                 32'h40, 32'h07FF_0001, 32'h40, 32'h0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_ptr();
        t_first_fetch();
        t_chain();
        t_sw_override();
        t_vsync_busy();
        t_misaligned();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule